// File: doc/BRIEF.md
# Codec Host Serial Port with Control Register

This block is the synchronous serial port through which a host processor exchanges samples with a voice-band codec. It runs in slave mode, one bit per clock cycle. A positive pulse on the frame-sync input marks each frame. The falling edge of that pulse starts a 32-bit frame, and a 16-bit slot in that frame carries one word each way, MSB first. The word arriving on the serial input goes to the DAC side on a parallel bus with a one-cycle strobe. The ADC word is taken from a parallel input and shifted out on the serial output.

Two mode pins are captured when the frame-sync pulse rises. They set whether a frame that carries data also asks for a control transfer. The request comes from the word's LSB in software mode, is never made in hardware data-only mode, and is always made in hardware mode with register access. The frame after a request is a control frame. Its incoming word is written into a 16-bit configuration register, and the serial output returns the register contents that were held before the write. If the host does not send the control frame within a set window after the requesting frame starts, the request is dropped and data transfer carries on. A slot-select pin places the word in the first or the second half of the frame, so two codecs can share one bus.

Top module: `codec_serial_port`

## Requirements
- R1: After reset ctrl_word is 16'h0300 (bits 8 and 9 set, all others clear), dac_valid and sdout are 0, and the first frame is a data frame.
- R2: In a data frame the 16 bits on sdin in the slot, MSB first, appear on dac_word. dac_valid is high for exactly one cycle, the cycle after the last slot bit is sampled.
- R3: adc_word is captured at the clock edge just before the first slot bit and is shifted out MSB first on sdout, one bit per slot cycle. Changes to adc_word during the slot have no effect.
- R4: With slot_hi=0 the slot is frame cycles 0–15 after the detected falling edge. With slot_hi=1 it is cycles 16–31. Outside the slot, sdout is 0.
- R5: hc_sel is sampled only on the clock edge where the fsync rise is detected. Later changes have no effect on that frame.
- R6: With hc_sel=00 (software mode) and word bit 0 = 0, the next frame is a data frame. In software mode, bit 0 of dac_word always reads 0.
- R7: With hc_sel=00 and word bit 0 = 1, the next frame is a control frame.
- R8: With hc_sel=01, all 16 bits reach dac_word and no control frame follows, whatever bit 0 is.
- R9: With hc_sel[1]=1, all 16 bits reach dac_word and the next frame is a control frame.
- R10: In a control frame, sdout returns ctrl_word as it was before the frame. At the slot end the received word is written to ctrl_word, and no dac_valid is raised.
- R11: If a control frame is requested but no frame starts within SEC_WINDOW cycles of the requesting frame's start, the request lapses. The next frame is a data frame and ctrl_word is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one serial bit per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| fsync | input | 1 | Frame-sync pulse; rise samples mode, fall starts frame |
| hc_sel | input | 2 | Transfer mode select pins |
| slot_hi | input | 1 | 0: first half of frame, 1: second half |
| sdin | input | 1 | Serial data from host |
| sdout | output | 1 | Serial data to host |
| adc_word | input | 16 | Parallel ADC sample |
| dac_word | output | 16 | Parallel DAC sample |
| dac_valid | output | 1 | One-cycle strobe for dac_word |
| ctrl_word | output | 16 | Configuration register contents |

## Verification
A lost or stale control request shows up in the frame after the fault. That frame writes ctrl_word when it should pulse dac_valid, or the reverse, so the fault is visible at the end of the very next slot. A bit counter or slot offset that is out by one misaligns every serial bit in the same frame. The host then sees a shifted word on both dac_word and sdout, and sdout goes non-zero outside the slot. A register that was written wrongly is returned on sdout by the next control frame.

// File: rtl/codec_port_pkg.sv
// Shared types for the codec serial port.
// Assumes 16-bit words; the register layout below matches that width.
package codec_port_pkg;

    // Mode pin encodings
    typedef enum logic [1:0] {
        HC_SW      = 2'b00,
        HC_HW_DATA = 2'b01,
        HC_HW_REGA = 2'b10,
        HC_HW_REGB = 2'b11
    } hc_mode_t;

    // Configuration register layout, MSB first
    typedef struct packed {
        logic [1:0] test_hi;
        logic [1:0] mdiv_test;
        logic [2:0] qdiv;
        logic       mdiv;
        logic [1:0] tx_atten;
        logic [2:0] osr_code;
        logic       rx_gain;
        logic       aux_sel;
        logic       spare0;
    } ctrl_reg_t;

    localparam logic [15:0] CTRL_RESET = 16'h0300;

endpackage

// File: rtl/csp_frame_ctrl.sv
// Frame sequencer: detects fsync edges, latches the mode pins, counts frame
// bits, and decides whether each frame carries data or control.
// Assumes WORD_W is a power of two and SEC_WINDOW > 2*WORD_W.
module csp_frame_ctrl
    import codec_port_pkg::*;
#(
    parameter int WORD_W     = 16,
    parameter int SEC_WINDOW = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fsync,
    input  logic [1:0] hc_sel,
    input  logic slot_hi,
    input  logic sdin,
    output logic shift_en,
    output logic word_done,
    output logic load_tx,
    output logic load_sec,
    output logic frame_sec,
    output logic sw_mode,
    output logic frame_active
);
    localparam int CW = $clog2(2 * WORD_W);
    localparam int TW = $clog2(SEC_WINDOW + 1);
    localparam logic [CW-1:0] LAST_BIT = CW'(2 * WORD_W - 1);
    localparam logic [CW-2:0] SLOT_END = (CW-1)'(WORD_W - 1);
    localparam logic [TW-1:0] WIN_MAX  = TW'(SEC_WINDOW);

    logic          fs_q;
    hc_mode_t      hc_q;
    logic          active;
    logic [CW-1:0] cnt;
    logic          slot_q;
    logic          sec_q;
    logic          pending;
    logic [TW-1:0] tmr;

    logic rise, fall, sec_go, req;

    // Edge detection and frame-type decision
    always_comb begin
        rise   = fsync & ~fs_q;
        fall   = ~fsync & fs_q;
        sec_go = pending && (tmr < WIN_MAX);
        req    = (hc_q == HC_SW) ? sdin : hc_q[1];
    end

    // Slot strobes derived from counter and latched slot choice
    always_comb begin
        shift_en  = active && (cnt[CW-1] == slot_q);
        word_done = shift_en && (cnt[CW-2:0] == SLOT_END);
        load_tx   = (fall && !slot_hi) ||
                    (active && slot_q && !cnt[CW-1] && (cnt[CW-2:0] == SLOT_END));
        load_sec  = fall ? sec_go : sec_q;
        frame_sec = sec_q;
        sw_mode   = (hc_q == HC_SW);
        frame_active = active;
    end

    // Sequencer state update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_q    <= 1'b0;
            hc_q    <= HC_SW;
            active  <= 1'b0;
            cnt     <= '0;
            slot_q  <= 1'b0;
            sec_q   <= 1'b0;
            pending <= 1'b0;
            tmr     <= '0;
        end else begin
            fs_q <= fsync;
            if (rise) hc_q <= hc_mode_t'(hc_sel);
            if (fall) begin
                active  <= 1'b1;
                cnt     <= '0;
                slot_q  <= slot_hi;
                sec_q   <= sec_go;
                pending <= 1'b0;
                tmr     <= '0;
            end else begin
                if (active) begin
                    cnt <= cnt + 1'b1;
                    if (cnt == LAST_BIT) active <= 1'b0;
                end
                if (tmr != WIN_MAX) tmr <= tmr + 1'b1;
                if (word_done && !sec_q) pending <= req;
                else if (tmr == WIN_MAX) pending <= 1'b0;
            end
        end
    end

    AST_TMR_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        tmr <= WIN_MAX); // R11
    AST_LOAD_OUTSIDE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        load_tx |-> !shift_en); // R4
endmodule

// File: rtl/csp_shifter.sv
// Serial datapath: receive shifter, transmit shifter, DAC word output.
// Assumes the sequencer asserts load_tx before the first slot bit.
module csp_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              word_done,
    input  logic              load_tx,
    input  logic              load_sec,
    input  logic              frame_sec,
    input  logic              sw_mode,
    input  logic              sdin,
    input  logic [WORD_W-1:0] adc_word,
    input  logic [WORD_W-1:0] reg_word,
    output logic              tx_bit,
    output logic [WORD_W-1:0] dac_word,
    output logic              dac_valid,
    output logic              wr_en,
    output logic [WORD_W-1:0] wr_data
);
    logic [WORD_W-1:0] rx_sh, tx_sh, full;

    // Complete word including the bit on the wire this cycle
    always_comb begin
        full    = {rx_sh[WORD_W-2:0], sdin};
        wr_en   = word_done && frame_sec;
        wr_data = full;
        tx_bit  = tx_sh[WORD_W-1];
    end

    // Shift registers and DAC output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sh     <= '0;
            tx_sh     <= '0;
            dac_word  <= '0;
            dac_valid <= 1'b0;
        end else begin
            if (shift_en) rx_sh <= full;
            if (load_tx) tx_sh <= load_sec ? reg_word : adc_word;
            else if (shift_en) tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
            dac_valid <= word_done && !frame_sec;
            if (word_done && !frame_sec)
                dac_word <= sw_mode ? {full[WORD_W-1:1], 1'b0} : full;
        end
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        dac_valid |=> !dac_valid); // R2
endmodule

// File: rtl/csp_ctrl_reg.sv
// Configuration register: loaded only by a completed control-frame word.
// Assumes wr_en is a single-cycle pulse from the datapath.
module csp_ctrl_reg
    import codec_port_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    output logic [15:0] ctrl_word
);
    ctrl_reg_t cfg_q;

    // Register update with reset defaults
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= ctrl_reg_t'(CTRL_RESET);
        else if (wr_en) cfg_q <= ctrl_reg_t'(wr_data);
    end

    assign ctrl_word = 16'(cfg_q);
endmodule

// File: rtl/codec_serial_port.sv
// Top of the codec host serial port (slave mode, one bit per clock).
// Assumes frames start at least 2*WORD_W+2 cycles apart.
module codec_serial_port #(
    parameter int WORD_W     = 16,
    parameter int SEC_WINDOW = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fsync,
    input  logic [1:0]        hc_sel,
    input  logic              slot_hi,
    input  logic              sdin,
    output logic              sdout,
    input  logic [WORD_W-1:0] adc_word,
    output logic [WORD_W-1:0] dac_word,
    output logic              dac_valid,
    output logic [WORD_W-1:0] ctrl_word
);
    logic shift_en, word_done, load_tx, load_sec, frame_sec, sw_mode, frame_active;
    logic tx_bit, wr_en;
    logic [WORD_W-1:0] wr_data;

    csp_frame_ctrl #(.WORD_W(WORD_W), .SEC_WINDOW(SEC_WINDOW)) u_seq (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .hc_sel(hc_sel),
        .slot_hi(slot_hi), .sdin(sdin), .shift_en(shift_en),
        .word_done(word_done), .load_tx(load_tx), .load_sec(load_sec),
        .frame_sec(frame_sec), .sw_mode(sw_mode), .frame_active(frame_active)
    );

    csp_shifter #(.WORD_W(WORD_W)) u_dp (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .word_done(word_done),
        .load_tx(load_tx), .load_sec(load_sec), .frame_sec(frame_sec),
        .sw_mode(sw_mode), .sdin(sdin), .adc_word(adc_word),
        .reg_word(ctrl_word), .tx_bit(tx_bit), .dac_word(dac_word),
        .dac_valid(dac_valid), .wr_en(wr_en), .wr_data(wr_data)
    );

    csp_ctrl_reg u_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .ctrl_word(ctrl_word)
    );

    // Serial output driven only inside the slot
    assign sdout = shift_en ? tx_bit : 1'b0;

    AST_CTRL_ONLY_SEC: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_word) |-> !dac_valid); // R10
    AST_SDOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_active |-> !sdout); // R4
endmodule

// File: tb/sim_codec_serial_port.sv
module sim_codec_serial_port;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fsync = 1'b0;
    logic [1:0] hc_sel = 2'b00;
    logic slot_hi = 1'b0;
    logic sdin = 1'b0;
    logic sdout;
    logic [15:0] adc_word = 16'h0;
    logic [15:0] dac_word, ctrl_word;
    logic dac_valid;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // Host-side model state
    bit          m_pend = 1'b0;
    logic [15:0] m_reg  = 16'h0300;
    string       m_tag  = "R1";

    always #5 clk = ~clk;

    codec_serial_port u0 (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .hc_sel(hc_sel),
        .slot_hi(slot_hi), .sdin(sdin), .sdout(sdout), .adc_word(adc_word),
        .dac_word(dac_word), .dac_valid(dac_valid), .ctrl_word(ctrl_word)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_dac(input logic [1:0] hc, input logic [15:0] w);
        return (hc == 2'b00) ? {w[15:1], 1'b0} : w;
    endfunction

    function automatic bit exp_req(input logic [1:0] hc, input logic [15:0] w);
        return (hc == 2'b00) ? w[0] : hc[1];
    endfunction

    function automatic string next_tag(input logic [1:0] hc, input logic [15:0] w);
        if (hc == 2'b00) return w[0] ? "R7" : "R6";
        if (hc == 2'b01) return "R8";
        return "R9";
    endfunction

    // One frame: fsync pulse, 32 bit times plus two, then idle cycles
    task automatic do_frame(input logic ts, input logic [1:0] hc,
                            input logic [15:0] word, input int idle);
        int off = ts ? 16 : 0;
        bit is_sec = m_pend;
        logic [15:0] exp_out = is_sec ? m_reg : 16'h0;
        logic [15:0] got = 16'h0;
        bit stray = 1'b0;
        logic [15:0] adc = 16'($urandom);
        string tag = m_tag;
        @(negedge clk);
        fsync = 1'b1; hc_sel = hc; slot_hi = ts; adc_word = adc;
        if (!is_sec) exp_out = adc;
        @(negedge clk);
        fsync = 1'b0; hc_sel = ~hc; // R5: late change must be ignored
        for (int i = 0; i < 34; i++) begin
            @(negedge clk);
            if (i >= off && i < off + 16) begin
                sdin = word[15 - (i - off)];
                got[15 - (i - off)] = sdout;
            end else begin
                sdin = 1'($urandom);
                if (sdout !== 1'b0) stray = 1'b1;
            end
            if (i == off + 1) adc_word = 16'($urandom); // R3: post-capture change
            if (i == off + 16) begin
                if (is_sec) begin
                    chk(dac_valid === 1'b0, "R10", "strobe in control frame", 16'(dac_valid), 16'h0);
                    chk(ctrl_word === word, tag, "register write", ctrl_word, word);
                end else begin
                    chk(dac_valid === 1'b1, tag, "data strobe", 16'(dac_valid), 16'h1);
                    chk(dac_word === exp_dac(hc, word), (hc == 2'b00) ? "R6" : "R2",
                        "dac_word", dac_word, exp_dac(hc, word));
                    chk(ctrl_word === m_reg, tag, "register untouched", ctrl_word, m_reg);
                end
            end
            if (i == off + 17 && !is_sec)
                chk(dac_valid === 1'b0, "R2", "strobe width", 16'(dac_valid), 16'h0);
        end
        chk(got === exp_out, is_sec ? "R10" : "R3", "sdout word", got, exp_out);
        chk(!stray, "R4", "sdout outside slot", 16'(stray), 16'h0);
        if (is_sec) begin
            m_reg  = word;
            m_pend = 1'b0;
            m_tag  = "R1";
            m_tag  = "R6";
        end else begin
            m_pend = exp_req(hc, word);
            m_tag  = next_tag(hc, word);
        end
        repeat (idle) @(negedge clk);
        if (idle >= 40 && m_pend) begin
            m_pend = 1'b0;
            m_tag  = "R11";
        end
    endtask

    initial begin
        void'($urandom(32'h5eed));
        repeat (4) @(negedge clk);
        chk(ctrl_word === 16'h0300, "R1", "reset register", ctrl_word, 16'h0300);
        chk(dac_valid === 1'b0, "R1", "reset strobe", 16'(dac_valid), 16'h0);
        chk(sdout === 1'b0, "R1", "reset sdout", 16'(sdout), 16'h0);
        rst_n = 1'b1;
        // directed corner cases
        do_frame(1'b0, 2'b01, 16'hA5A5, 2);   // first frame is data; hw data-only with LSB 1
        do_frame(1'b1, 2'b00, 16'h1235, 2);   // sw mode LSB 1 requests control
        do_frame(1'b1, 2'b00, 16'hBEEF, 2);   // control frame, high slot
        do_frame(1'b0, 2'b10, 16'h8001, 2);   // hw with register access
        do_frame(1'b0, 2'b11, 16'h7FFE, 2);   // control frame, low slot
        do_frame(1'b0, 2'b00, 16'h4444, 2);   // sw mode LSB 0: data only
        do_frame(1'b0, 2'b11, 16'h0F0F, 45);  // request left to lapse
        do_frame(1'b1, 2'b01, 16'hFFFF, 2);   // must be data frame
        // random traffic
        for (int n = 0; n < 40; n++) begin
            do_frame(1'($urandom), 2'($urandom), 16'($urandom),
                     ($urandom % 8 == 0) ? 45 : int'($urandom % 10));
        end
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: run hung act=%h exp=%h", 16'h0, 16'h1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule